// File: doc/BRIEF.md
# ECC Memory Controller Register Block

This block holds the software-visible control and status words of an ECC memory controller. A bus master reaches nine 32-bit words through a simple valid/write/address/data port. The word index comes from address bits [5:2]. Read data is registered and appears on the cycle after the request. A hardware error-report strobe from the checking logic records fault status and the faulting address. It raises an interrupt that software clears by writing the fault status word.

The parameter `VARIANT` (0, 1 or 2) selects the controller flavour. It sets the variant tag held in the top nibble of the enable word and the bits of that word that software may write. It also decides which enable fields survive a soft reset, and whether a four-byte diagnostic window exists. The block has two reset inputs. `por_n` loads the power-on image, including the variant tag. `rst_n` is a soft reset that keeps the preserved enable fields and the diagnostic bytes.

Top module: `ecc_csr_block`

## Requirements
- R1: After power-on reset the word at index 0 (enable) reads VARIANT<<28, index 1 (delay) reads 0x00000020, index 4 (fault address 0) reads 0x07C00000, every other index reads zero and irq is low.
- R2: A write to index 0 stores data AND 0x00000103 for variant 0. For variants 1 and 2 it stores (VARIANT<<28) OR (data AND 0x00000BFF). Bits [31:24] of the enable word always equal the variant tag.
- R3: A soft reset (rst_n low for one clock) ANDs the enable word with 0x00000100 for variant 0 or with 0xFF000BFC for variants 1 and 2. It returns every other word to its R1 value and drops irq. It leaves the diagnostic bytes intact.
- R4: A write to index 1 stores data AND 0x7FFFFFFF.
- R5: Indexes 3 (video config), 6 (diagnostic control), 7 (error control 0) and 8 (error control 1) each store and return a full 32-bit value in separate storage. Read data appears on bus_rdata one clock after the read request and holds until the next read.
- R6: Bus writes to index 4 (fault address 0) and index 5 (fault address 1) have no effect.
- R7: Indexes 9 to 15 read as zero, and writes to them change no register.
- R8: With enable bit 1 set and fault status bits 0 and 3 both clear, an error strobe loads fault status with syndrome<<8 | uncorr<<3 | !uncorr and loads fault address 1 with err_addr. It raises irq at the next clock.
- R9: With enable bit 1 set and fault status bit 0 or bit 3 already set, an error strobe only sets fault status bit 16. The syndrome, flags and fault address 1 are kept, and irq is high at the next clock.
- R10: With enable bit 1 clear, an error strobe changes neither fault status, fault address 1 nor irq.
- R11: A bus write to index 2 (fault status) stores the full 32-bit value and drops irq at the next clock. A strobe arriving in the same cycle is discarded.
- R12: For variant 0, accesses with bus_diag high reach byte bus_addr[1:0] of a four-byte window. A write stores bus_wdata[7:0] and a read returns the byte zero-extended. For variants 1 and 2 such reads return zero and such writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous soft reset, active low |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_diag | input | 1 | Selects the diagnostic byte window instead of the word bank |
| bus_addr | input | ADDR_W | Byte address; bits [5:2] pick the word, bits [1:0] the diagnostic byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| err_strobe | input | 1 | One-cycle error report |
| err_uncorr | input | 1 | 1 = uncorrectable, 0 = correctable |
| err_syndrome | input | SYN_W | Syndrome of the reported error |
| err_addr | input | 32 | Address of the reported error |
| irq | output | 1 | Fault interrupt |

## Verification
A wrong enable mask or a lost variant tag shows on the next read of index 0, one clock after the request. A wrong fault-capture path shows on irq at the clock after the strobe. A faulty multiple-error merge shows as a changed syndrome or fault address on the next read of index 2 or 5. Storage that aliases or leaks between words shows only when the other word is read back, so the bench writes distinct patterns to all writable words before reading any of them.

// File: rtl/ecc_csr_pkg.sv
package ecc_csr_pkg;

    localparam int WORD_W   = 32;
    localparam int NUM_REGS = 9;

    // word indexes; the order is the bus map
    localparam int REG_ENABLE = 0;
    localparam int REG_DELAY  = 1;
    localparam int REG_FSTAT  = 2;
    localparam int REG_VIDCFG = 3;
    localparam int REG_FADDR0 = 4;
    localparam int REG_FADDR1 = 5;
    localparam int REG_DGCTL  = 6;
    localparam int REG_ECTL0  = 7;
    localparam int REG_ECTL1  = 8;

    localparam logic [WORD_W-1:0] DELAY_RST   = 32'h0000_0020;
    localparam logic [WORD_W-1:0] FADDR0_RST  = 32'h07C0_0000;
    localparam logic [WORD_W-1:0] DELAY_WMASK = 32'h7FFF_FFFF;

    // fault status fields
    localparam int FS_CE     = 0;
    localparam int FS_UE     = 3;
    localparam int FS_SYN_LO = 8;
    localparam int FS_ME     = 16;

    localparam int EN_IRQ_BIT = 1;

    function automatic logic [WORD_W-1:0] variant_tag(input int v);
        return WORD_W'(v) << 28;
    endfunction

    function automatic logic [WORD_W-1:0] enable_wmask(input int v);
        return (v == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
    endfunction

    function automatic logic [WORD_W-1:0] enable_keep(input int v);
        return (v == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
    endfunction

    typedef struct packed {
        logic [WORD_W-1:0] enable;
        logic [WORD_W-1:0] delay;
        logic [WORD_W-1:0] fstat;
        logic [WORD_W-1:0] vidcfg;
        logic [WORD_W-1:0] faddr0;
        logic [WORD_W-1:0] faddr1;
        logic [WORD_W-1:0] dgctl;
        logic [WORD_W-1:0] ectl0;
        logic [WORD_W-1:0] ectl1;
        logic              irq;
        logic [WORD_W-1:0] rdata;
    } csr_state_t;

endpackage

// File: rtl/ecc_csr_decode.sv
module ecc_csr_decode #(
    parameter int ADDR_W   = 6,
    parameter int NUM_REGS = 9,
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic                bus_diag,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic [NUM_REGS-1:0] reg_wr,
    output logic                reg_rd,
    output logic [IDX_W-1:0]    reg_idx,
    output logic                diag_wr,
    output logic                diag_rd,
    output logic [1:0]          byte_sel
);
    logic bank_access;

    assign reg_idx     = bus_addr[ADDR_W-1:2];
    assign byte_sel    = bus_addr[1:0];
    assign bank_access = bus_valid & ~bus_diag;
    assign reg_rd      = bank_access & ~bus_write;
    assign diag_wr     = bus_valid & bus_diag & bus_write;
    assign diag_rd     = bus_valid & bus_diag & ~bus_write;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_wr
        assign reg_wr[g] = bank_access & bus_write & (reg_idx == IDX_W'(g));
    end
endmodule

// File: rtl/ecc_fault_capture.sv
module ecc_fault_capture #(
    parameter int SYN_W = 8,
    parameter int WW    = 32
) (
    input  logic [WW-1:0]    fstat_q,
    input  logic [WW-1:0]    faddr1_q,
    input  logic             irq_q,
    input  logic             irq_enable,
    input  logic             fstat_wr,
    input  logic [WW-1:0]    wdata,
    input  logic             strobe,
    input  logic             uncorr,
    input  logic [SYN_W-1:0] syndrome,
    input  logic [WW-1:0]    fault_addr,
    output logic [WW-1:0]    fstat_d,
    output logic [WW-1:0]    faddr1_d,
    output logic             irq_d
);
    import ecc_csr_pkg::*;

    logic prior_err;
    assign prior_err = fstat_q[FS_CE] | fstat_q[FS_UE];

    always_comb begin
        fstat_d  = fstat_q;
        faddr1_d = faddr1_q;
        irq_d    = irq_q;
        if (fstat_wr) begin
            // bus write wins over a same-cycle report
            fstat_d = wdata;
            irq_d   = 1'b0;
        end else if (strobe && irq_enable) begin
            irq_d = 1'b1;
            if (prior_err) begin
                fstat_d[FS_ME] = 1'b1;
            end else begin
                fstat_d                       = '0;
                fstat_d[FS_CE]                = ~uncorr;
                fstat_d[FS_UE]                = uncorr;
                fstat_d[FS_SYN_LO +: SYN_W]   = syndrome;
                faddr1_d                      = fault_addr;
            end
        end
    end
endmodule

// File: rtl/ecc_diag_window.sv
module ecc_diag_window #(
    parameter bit PRESENT = 1'b1,
    parameter int BYTES   = 4,
    localparam int SEL_W  = $clog2(BYTES)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [7:0]       wbyte,
    output logic [7:0]       rbyte
);
    if (PRESENT) begin : g_win
        logic [7:0] mem_q [BYTES];
        logic [7:0] mem_d [BYTES];

        always_comb begin
            for (int k = 0; k < BYTES; k++) mem_d[k] = mem_q[k];
            if (wr_en) mem_d[sel] = wbyte;
        end

        always_ff @(posedge clk) begin
            for (int k = 0; k < BYTES; k++) begin
                if (!por_n) mem_q[k] <= '0;
                else        mem_q[k] <= mem_d[k];
            end
        end

        assign rbyte = mem_q[sel];
    end else begin : g_none
        assign rbyte = '0;
    end
endmodule

// File: rtl/ecc_csr_block.sv
module ecc_csr_block #(
    parameter int VARIANT = 0,
    parameter int ADDR_W  = 6,
    parameter int SYN_W   = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_diag,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              err_strobe,
    input  logic              err_uncorr,
    input  logic [SYN_W-1:0]  err_syndrome,
    input  logic [31:0]       err_addr,
    output logic              irq
);
    import ecc_csr_pkg::*;

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] VTAG   = variant_tag(VARIANT);
    localparam logic [WORD_W-1:0] EN_WM  = enable_wmask(VARIANT);
    localparam logic [WORD_W-1:0] EN_KP  = enable_keep(VARIANT);
    localparam bit HAS_TAG  = (VARIANT != 0);
    localparam bit HAS_DIAG = (VARIANT == 0);

    localparam csr_state_t POR_STATE = '{
        enable: VTAG,   delay: DELAY_RST, fstat: '0,  vidcfg: '0,
        faddr0: FADDR0_RST, faddr1: '0,   dgctl: '0,  ectl0: '0,
        ectl1: '0,      irq: 1'b0,        rdata: '0
    };

    csr_state_t cur_q, nxt_d;

    logic [NUM_REGS-1:0] wr_hit;
    logic                reg_rd, diag_wr, diag_rd;
    logic [IDX_W-1:0]    reg_idx;
    logic [1:0]          byte_sel;
    logic [7:0]          diag_byte;
    logic [WORD_W-1:0]   fstat_d, faddr1_d;
    logic                irq_d;
    logic [WORD_W-1:0]   bank [NUM_REGS];
    logic [WORD_W-1:0]   rd_word;

    ecc_csr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_diag  (bus_diag),
        .bus_addr  (bus_addr),
        .reg_wr    (wr_hit),
        .reg_rd    (reg_rd),
        .reg_idx   (reg_idx),
        .diag_wr   (diag_wr),
        .diag_rd   (diag_rd),
        .byte_sel  (byte_sel)
    );

    ecc_fault_capture #(.SYN_W(SYN_W), .WW(WORD_W)) u_fault (
        .fstat_q    (cur_q.fstat),
        .faddr1_q   (cur_q.faddr1),
        .irq_q      (cur_q.irq),
        .irq_enable (cur_q.enable[EN_IRQ_BIT]),
        .fstat_wr   (wr_hit[REG_FSTAT]),
        .wdata      (bus_wdata),
        .strobe     (err_strobe),
        .uncorr     (err_uncorr),
        .syndrome   (err_syndrome),
        .fault_addr (err_addr),
        .fstat_d    (fstat_d),
        .faddr1_d   (faddr1_d),
        .irq_d      (irq_d)
    );

    ecc_diag_window #(.PRESENT(HAS_DIAG), .BYTES(4)) u_diag (
        .clk   (clk),
        .por_n (por_n),
        .wr_en (diag_wr),
        .sel   (byte_sel),
        .wbyte (bus_wdata[7:0]),
        .rbyte (diag_byte)
    );

    // readable view of the bank in map order
    always_comb begin
        bank[REG_ENABLE] = cur_q.enable;
        bank[REG_DELAY]  = cur_q.delay;
        bank[REG_FSTAT]  = cur_q.fstat;
        bank[REG_VIDCFG] = cur_q.vidcfg;
        bank[REG_FADDR0] = cur_q.faddr0;
        bank[REG_FADDR1] = cur_q.faddr1;
        bank[REG_DGCTL]  = cur_q.dgctl;
        bank[REG_ECTL0]  = cur_q.ectl0;
        bank[REG_ECTL1]  = cur_q.ectl1;
    end

    always_comb begin
        rd_word = '0;
        if (diag_rd) begin
            rd_word = {24'b0, diag_byte};
        end else begin
            for (int k = 0; k < NUM_REGS; k++) begin
                if (reg_idx == IDX_W'(k)) rd_word = bank[k];
            end
        end
    end

    always_comb begin
        nxt_d = cur_q;
        if (wr_hit[REG_ENABLE]) begin
            nxt_d.enable = HAS_TAG ? (VTAG | (bus_wdata & EN_WM)) : (bus_wdata & EN_WM);
        end
        if (wr_hit[REG_DELAY])  nxt_d.delay  = bus_wdata & DELAY_WMASK;
        if (wr_hit[REG_VIDCFG]) nxt_d.vidcfg = bus_wdata;
        if (wr_hit[REG_DGCTL])  nxt_d.dgctl  = bus_wdata;
        if (wr_hit[REG_ECTL0])  nxt_d.ectl0  = bus_wdata;
        if (wr_hit[REG_ECTL1])  nxt_d.ectl1  = bus_wdata;
        nxt_d.fstat  = fstat_d;
        nxt_d.faddr1 = faddr1_d;
        nxt_d.irq    = irq_d;
        if (reg_rd || diag_rd) nxt_d.rdata = rd_word;
        if (!rst_n) begin
            nxt_d        = POR_STATE;
            nxt_d.enable = cur_q.enable & EN_KP;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) cur_q <= POR_STATE;
        else        cur_q <= nxt_d;
    end

    assign bus_rdata = cur_q.rdata;
    assign irq       = cur_q.irq;

    AST_TAG_KEPT: assert property (@(posedge clk) disable iff (!por_n)
        por_n |=> (cur_q.enable[31:24] == VTAG[31:24])); // R2
    AST_DELAY_TOP_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        wr_hit[REG_DELAY] |=> !cur_q.delay[31]); // R4
    AST_FADDR0_FIXED: assert property (@(posedge clk) disable iff (!por_n)
        por_n |=> $stable(cur_q.faddr0)); // R6
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (err_strobe && cur_q.enable[EN_IRQ_BIT] && !wr_hit[REG_FSTAT]) |=> irq); // R8
    AST_ME_KEEPS_SYN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (err_strobe && cur_q.enable[EN_IRQ_BIT] && !wr_hit[REG_FSTAT] &&
         (cur_q.fstat[FS_CE] || cur_q.fstat[FS_UE]))
        |=> ($stable(cur_q.fstat[15:0]) && $stable(cur_q.faddr1) && cur_q.fstat[FS_ME])); // R9
    AST_NO_ACCEPT: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (err_strobe && !cur_q.enable[EN_IRQ_BIT] && !wr_hit[REG_FSTAT] && !irq)
        |=> (!irq && $stable(cur_q.fstat))); // R10
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        wr_hit[REG_FSTAT] |=> !irq); // R11
endmodule

// File: tb/ecc_csr_block_tb_top.sv
`timescale 1ns/1ps
module ecc_csr_block_tb_top;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_diag = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        err_strobe = 1'b0, err_uncorr = 1'b0;
    logic [7:0]  err_syndrome = '0;
    logic [31:0] err_addr = '0;
    logic [31:0] rd [3];
    logic        irq_v [3];

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    for (genvar v = 0; v < 3; v++) begin : g_var
        ecc_csr_block #(.VARIANT(v)) dut_i (
            .clk(clk), .por_n(por_n), .rst_n(rst_n),
            .bus_valid(bus_valid), .bus_write(bus_write), .bus_diag(bus_diag),
            .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd[v]),
            .err_strobe(err_strobe), .err_uncorr(err_uncorr),
            .err_syndrome(err_syndrome), .err_addr(err_addr), .irq(irq_v[v])
        );
    end

    function automatic logic [31:0] exp_en(input int v, input logic [31:0] d);
        return (v == 0) ? (d & 32'h103) : ((32'(v) << 28) | (d & 32'hBFF));
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input int idx, input logic [31:0] d, input logic dsel);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_diag = dsel;
        bus_addr = 6'(idx); bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_diag = 1'b0;
    endtask

    task automatic bus_rd(input int idx, input logic dsel);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_diag = dsel; bus_addr = 6'(idx);
        @(negedge clk);
        bus_valid = 1'b0; bus_diag = 1'b0;
    endtask

    // reads a word and compares each variant with its own expectation
    task automatic chk_rd(input string req, input string what, input int idx, input logic dsel,
                          input logic [31:0] e0, input logic [31:0] e1, input logic [31:0] e2);
        bus_rd(idx, dsel);
        check(req, {what, " v0"}, rd[0], e0);
        check(req, {what, " v1"}, rd[1], e1);
        check(req, {what, " v2"}, rd[2], e2);
    endtask

    task automatic chk_irq(input string req, input logic e);
        for (int v = 0; v < 3; v++) check(req, "irq", 32'(irq_v[v]), 32'(e));
    endtask

    task automatic strobe(input logic unc, input logic [7:0] syn, input logic [31:0] a,
                          input logic with_fs_wr, input logic [31:0] fs_val);
        @(negedge clk);
        err_strobe = 1'b1; err_uncorr = unc; err_syndrome = syn; err_addr = a;
        if (with_fs_wr) begin
            bus_valid = 1'b1; bus_write = 1'b1; bus_diag = 1'b0;
            bus_addr = 6'(2 << 2); bus_wdata = fs_val;
        end
        @(negedge clk);
        err_strobe = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    function automatic int A(input int idx);
        return idx << 2;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1 power-on image
        chk_irq("R1", 1'b0);
        chk_rd("R1", "enable", A(0), 0, 32'h0, 32'h1000_0000, 32'h2000_0000);
        chk_rd("R1", "delay",  A(1), 0, 32'h20, 32'h20, 32'h20);
        chk_rd("R1", "faddr0", A(4), 0, 32'h07C0_0000, 32'h07C0_0000, 32'h07C0_0000);
        for (int i = 2; i < 9; i++) begin
            if (i != 4) chk_rd("R1", $sformatf("idx%0d", i), A(i), 0, 0, 0, 0);
        end

        // R2 enable write masks
        begin
            logic [31:0] pats [4] = '{32'hFFFF_FFFF, 32'h0, 32'hA5A5_A5A5, 32'h5A5A_5A5A};
            for (int p = 0; p < 4; p++) begin
                bus_wr(A(0), pats[p], 0);
                chk_rd("R2", "enable", A(0), 0, exp_en(0, pats[p]), exp_en(1, pats[p]), exp_en(2, pats[p]));
            end
        end

        // R4 delay mask
        begin
            logic [31:0] dp [3] = '{32'hFFFF_FFFF, 32'h8000_0001, 32'h1234_5678};
            for (int p = 0; p < 3; p++) begin
                bus_wr(A(1), dp[p], 0);
                chk_rd("R4", "delay", A(1), 0, dp[p] & 32'h7FFF_FFFF,
                       dp[p] & 32'h7FFF_FFFF, dp[p] & 32'h7FFF_FFFF);
            end
        end

        // R5 plain words, separate storage, two patterns
        for (int p = 0; p < 2; p++) begin
            int ids [4] = '{3, 6, 7, 8};
            for (int k = 0; k < 4; k++) bus_wr(A(ids[k]), (32'h1111_1111 * (k + 1)) ^ (p != 0 ? 32'hFFFF_0000 : 32'h0), 0);
            for (int k = 0; k < 4; k++) begin
                logic [31:0] e;
                e = (32'h1111_1111 * (k + 1)) ^ (p != 0 ? 32'hFFFF_0000 : 32'h0);
                chk_rd("R5", $sformatf("idx%0d", ids[k]), A(ids[k]), 0, e, e, e);
            end
        end
        // R5 read data holds when no read is issued
        repeat (2) @(negedge clk);
        for (int v = 0; v < 3; v++) check("R5", "rdata hold", rd[v], 32'h4444_4444 ^ 32'hFFFF_0000);

        // R6 fault address words ignore writes
        bus_wr(A(4), 32'hFFFF_FFFF, 0);
        bus_wr(A(5), 32'hFFFF_FFFF, 0);
        chk_rd("R6", "faddr0", A(4), 0, 32'h07C0_0000, 32'h07C0_0000, 32'h07C0_0000);
        chk_rd("R6", "faddr1", A(5), 0, 0, 0, 0);

        // R7 unmapped indexes
        for (int i = 9; i < 16; i++) begin
            bus_wr(A(i), 32'hFFFF_FFFF, 0);
            chk_rd("R7", $sformatf("idx%0d", i), A(i), 0, 0, 0, 0);
        end
        chk_rd("R7", "enable kept", A(0), 0, exp_en(0, 32'h5A5A_5A5A), exp_en(1, 32'h5A5A_5A5A), exp_en(2, 32'h5A5A_5A5A));
        chk_rd("R7", "delay kept", A(1), 0, 32'h1234_5678, 32'h1234_5678, 32'h1234_5678);

        // R12 diagnostic window
        for (int b = 0; b < 4; b++) bus_wr(b, 32'hABCD_EF00 | (32'h3C + 32'(b) * 32'h11), 1);
        for (int b = 0; b < 4; b++) chk_rd("R12", $sformatf("byte%0d", b), b, 1, 32'h3C + 32'(b) * 32'h11, 0, 0);
        chk_rd("R12", "bank untouched", A(0), 0, exp_en(0, 32'h5A5A_5A5A), exp_en(1, 32'h5A5A_5A5A), exp_en(2, 32'h5A5A_5A5A));

        // R10 strobe with interrupt enable clear
        bus_wr(A(0), 32'h0, 0);
        strobe(1'b1, 8'h77, 32'h0000_1000, 0, 0);
        chk_irq("R10", 1'b0);
        chk_rd("R10", "fstat", A(2), 0, 0, 0, 0);
        chk_rd("R10", "faddr1", A(5), 0, 0, 0, 0);

        // R8 first error captured
        bus_wr(A(0), 32'h2, 0);
        strobe(1'b0, 8'h5A, 32'h1234_5678, 0, 0);
        chk_irq("R8", 1'b1);
        chk_rd("R8", "fstat", A(2), 0, 32'h5A01, 32'h5A01, 32'h5A01);
        chk_rd("R8", "faddr1", A(5), 0, 32'h1234_5678, 32'h1234_5678, 32'h1234_5678);

        // R9 second error only flags multiple
        strobe(1'b1, 8'h33, 32'hDEAD_BEEF, 0, 0);
        chk_irq("R9", 1'b1);
        chk_rd("R9", "fstat", A(2), 0, 32'h1_5A01, 32'h1_5A01, 32'h1_5A01);
        chk_rd("R9", "faddr1", A(5), 0, 32'h1234_5678, 32'h1234_5678, 32'h1234_5678);

        // R11 status write clears irq, then fresh capture, then write beats strobe
        bus_wr(A(2), 32'h0, 0);
        chk_irq("R11", 1'b0);
        chk_rd("R11", "fstat", A(2), 0, 0, 0, 0);
        strobe(1'b1, 8'hC3, 32'hCAFE_0000, 0, 0);
        chk_irq("R8", 1'b1);
        chk_rd("R8", "fstat uncorr", A(2), 0, 32'hC308, 32'hC308, 32'hC308);
        strobe(1'b0, 8'h11, 32'h0BAD_0000, 1, 32'hF0F0_00F0);
        chk_irq("R11", 1'b0);
        chk_rd("R11", "fstat wins", A(2), 0, 32'hF0F0_00F0, 32'hF0F0_00F0, 32'hF0F0_00F0);
        chk_rd("R11", "faddr1 kept", A(5), 0, 32'hCAFE_0000, 32'hCAFE_0000, 32'hCAFE_0000);

        // R3 soft reset
        bus_wr(A(0), 32'hFFFF_FFFF, 0);
        bus_wr(A(2), 32'h0, 0);
        bus_wr(A(3), 32'h55AA_55AA, 0);
        strobe(1'b0, 8'h01, 32'h0000_0040, 0, 0);
        chk_irq("R3", 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk_irq("R3", 1'b0);
        chk_rd("R3", "enable", A(0), 0, 32'h100, 32'h1000_0BFC, 32'h2000_0BFC);
        chk_rd("R3", "delay",  A(1), 0, 32'h20, 32'h20, 32'h20);
        chk_rd("R3", "fstat",  A(2), 0, 0, 0, 0);
        chk_rd("R3", "vidcfg", A(3), 0, 0, 0, 0);
        chk_rd("R3", "faddr0", A(4), 0, 32'h07C0_0000, 32'h07C0_0000, 32'h07C0_0000);
        chk_rd("R3", "faddr1", A(5), 0, 0, 0, 0);
        chk_rd("R3", "ectl1",  A(8), 0, 0, 0, 0);
        chk_rd("R3", "diag kept", 2, 1, 32'h5E, 0, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule